// File: doc/BRIEF.md
# Jack-Sense Debounce and Interrupt Controller

This block watches a 2-bit code from two external comparators that place the jack-sense voltage below, between or above two thresholds. It tells a host when a plug has been inserted, removed or reconfigured. A new code must stay unchanged for a debounce time that the host selects before the block accepts it. The block then shows the accepted code in a jack-status register and sets a sticky change flag. If the host has enabled it, that flag pulls an active-low interrupt line low.

The host uses a plain synchronous register port with an address, write and read strobes, write data and registered read data. The host enables detection, chooses the debounce time and unmasks the interrupt. When the interrupt arrives, the host reads the status register to service it, then reads the jack-status register to learn the new plug state. Debounce time is counted in ticks of a prescaled tick input, nominally one per millisecond.

Top module: `jack_irq_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and `irqN` is high.
- R2: The interrupt-enable register (0x04) and the configuration register (0x25) are read/write. Writes to the status register (0x00) and the jack-status register (0x01) are ignored. Unmapped addresses read 0x00. Read data appears on `regRdData` the cycle after `regRdEn` and holds until the next read.
- R3: `senseCode` passes through a two-stage synchronizer. Jack-status bits [7:6] show the last accepted code: 00 = low, 01 = mid, 11 = high, 10 = invalid. Invalid is debounced and reported like any other code. Bits [5:0] read 0.
- R4: A changed code is accepted once it has held for `BASE_TICKS << sel` cycles with `tickEn` high, where sel is configuration bits [1:0]. This gives 25, 50, 100 or 200 ticks by default. Cycles with `tickEn` low do not count.
- R5: Any new code seen while a count runs restarts the count. A code that returns to the accepted value before the count ends causes no change.
- R6: Each accepted change sets status bit 1, and that bit stays set until it is cleared.
- R7: A status-register read clears status bit 1. If a change is accepted on the same cycle as the read, the bit stays set.
- R8: `irqN` is low exactly when status bit 1 and interrupt-enable bit 1 are both set.
- R9: While configuration bit 7 (detect enable) is 0, nothing is detected, the counter is cleared and the jack status reads 00. When the bit is set again, the current code becomes the new baseline and no change is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Prescaled debounce tick, one cycle wide |
| senseCode | input | 2 | Comparator code, asynchronous to `clk` |
| regAddr | input | 8 | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 8 | Registered read data |
| irqN | output | 1 | Active-low interrupt |

## Verification
A wrong candidate code or a miscounted debounce counter moves the cycle on which `irqN` falls. The bench compares `irqN` on every clock, so the error shows as soon as the commit cycle differs. A lost or stuck flag shows as `irqN` staying low, or rising too early, on the cycle after a status read. A bad accepted code shows in the next jack-status read. Bounce patterns, tick gaps, all four debounce lengths, a read that coincides with a commit, and disable/re-enable each drive these faults to the ports within a few hundred cycles.

// File: rtl/jack_pkg.sv
package jack_pkg;
  localparam logic [7:0] ADDR_STATUS = 8'h00;
  localparam logic [7:0] ADDR_JACK   = 8'h01;
  localparam logic [7:0] ADDR_IRQEN  = 8'h04;
  localparam logic [7:0] ADDR_CFG    = 8'h25;
  localparam int FLAG_BIT   = 1;
  localparam int DET_EN_BIT = 7;

  typedef struct packed {
    logic clrAll;
    logic baseline;
    logic restart;
    logic inc;
    logic commit;
  } dbStrobe_t;
endpackage

// File: rtl/jack_ctrl.sv
module jack_ctrl
  import jack_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      detEn,
  input  logic      tickEn,
  input  logic      codeMoved,
  input  logic      candFresh,
  input  logic      atLimit,
  output dbStrobe_t strobe
);
  logic basePending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               basePending <= 1'b1;
    else if (!detEn)          basePending <= 1'b1;
    else if (strobe.baseline) basePending <= 1'b0;
  end

  always_comb begin
    strobe = '0;
    if (!detEn)                 strobe.clrAll   = 1'b1;
    else if (basePending)       strobe.baseline = 1'b1;
    else if (codeMoved)         strobe.restart  = 1'b1;
    else if (candFresh && tickEn) begin
      if (atLimit) strobe.commit = 1'b1;
      else         strobe.inc    = 1'b1;
    end
  end
endmodule

// File: rtl/jack_dp.sv
module jack_dp
  import jack_pkg::*;
#(
  parameter int BASE_TICKS = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] senseCode,
  input  logic [7:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       regRdEn,
  input  dbStrobe_t  strobe,
  output logic [7:0] regRdData,
  output logic       irqN,
  output logic       detEn,
  output logic       codeMoved,
  output logic       candFresh,
  output logic       atLimit,
  output logic [1:0] syncCode,
  output logic [1:0] candCode,
  output logic [1:0] jackCode,
  output logic       flag
);
  localparam int MAX_TICKS = BASE_TICKS * 8;
  localparam int CNT_W = $clog2(MAX_TICKS + 1);

  logic [1:0]       syncStage [SYNC_STAGES];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [7:0]       ieReg;
  logic [7:0]       cfgReg;
  logic             rdStatus;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      syncStage[i] <= 2'b00;
        else if (i == 0) syncStage[i] <= senseCode;
        else             syncStage[i] <= syncStage[(i > 0) ? i - 1 : 0];
      end
    end
  endgenerate

  assign syncCode  = syncStage[SYNC_STAGES-1];
  assign detEn     = cfgReg[DET_EN_BIT];
  assign limit     = CNT_W'(BASE_TICKS) << cfgReg[1:0];
  assign atLimit   = (cnt == limit - CNT_W'(1));
  assign codeMoved = (syncCode != candCode);
  assign candFresh = (candCode != jackCode);
  assign rdStatus  = regRdEn && (regAddr == ADDR_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      candCode <= 2'b00;
      jackCode <= 2'b00;
      cnt      <= '0;
    end else if (strobe.clrAll) begin
      candCode <= 2'b00;
      jackCode <= 2'b00;
      cnt      <= '0;
    end else if (strobe.baseline) begin
      candCode <= syncCode;
      jackCode <= syncCode;
      cnt      <= '0;
    end else if (strobe.restart) begin
      candCode <= syncCode;
      cnt      <= '0;
    end else if (strobe.commit) begin
      jackCode <= candCode;
      cnt      <= '0;
    end else if (strobe.inc) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= strobe.commit | (flag & ~rdStatus);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ieReg  <= '0;
      cfgReg <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_IRQEN) ieReg  <= regWrData;
      if (regAddr == ADDR_CFG)   cfgReg <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regRdData <= '0;
    else if (regRdEn) begin
      case (regAddr)
        ADDR_STATUS: regRdData <= 8'(flag) << FLAG_BIT;
        ADDR_JACK:   regRdData <= {jackCode, 6'b0};
        ADDR_IRQEN:  regRdData <= ieReg;
        ADDR_CFG:    regRdData <= cfgReg;
        default:     regRdData <= '0;
      endcase
    end
  end

  assign irqN = ~(flag & ieReg[FLAG_BIT]);
endmodule

// File: rtl/jack_irq_ctrl.sv
module jack_irq_ctrl
  import jack_pkg::*;
#(
  parameter int BASE_TICKS = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickEn,
  input  logic [1:0] senseCode,
  input  logic [7:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       regRdEn,
  output logic [7:0] regRdData,
  output logic       irqN
);
  dbStrobe_t  strobe;
  logic       detEn, codeMoved, candFresh, atLimit, flag;
  logic [1:0] syncCode, candCode, jackCode;

  jack_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .detEn(detEn), .tickEn(tickEn),
    .codeMoved(codeMoved), .candFresh(candFresh), .atLimit(atLimit),
    .strobe(strobe)
  );

  jack_dp #(.BASE_TICKS(BASE_TICKS), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rst_n(rst_n), .senseCode(senseCode),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .strobe(strobe), .regRdData(regRdData),
    .irqN(irqN), .detEn(detEn), .codeMoved(codeMoved),
    .candFresh(candFresh), .atLimit(atLimit), .syncCode(syncCode),
    .candCode(candCode), .jackCode(jackCode), .flag(flag)
  );
endmodule

// File: rtl/jack_irq_chk.sv
module jack_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irqN,
  input logic       tickEn,
  input logic       regRdEn,
  input logic [7:0] regAddr,
  input logic       commit,
  input logic       flag,
  input logic       detEn,
  input logic [1:0] syncCode,
  input logic [1:0] candCode,
  input logic [1:0] jackCode
);
  // R7
  read_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && regAddr == 8'h00 && !commit) |=> irqN);
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(regRdEn && regAddr == 8'h00)) |=> flag);
  // R4
  commit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> tickEn);
  // R5
  commit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (syncCode == candCode));
  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !detEn |=> (jackCode == 2'b00 && !commit));
  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irqN |-> flag);
endmodule

bind jack_irq_ctrl jack_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irqN(irqN), .tickEn(tickEn),
  .regRdEn(regRdEn), .regAddr(regAddr), .commit(strobe.commit),
  .flag(flag), .detEn(detEn), .syncCode(syncCode),
  .candCode(candCode), .jackCode(jackCode)
);

// File: tb/jack_irq_ctrl_test.sv
module jack_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 25;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b0;
  logic [1:0] senseCode = 2'b00;
  logic [7:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic       regRdEn = 1'b0;
  logic [7:0] regRdData;
  logic       irqN;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int tickDiv = 1;
  string curReq = "R1";
  bit done = 0;

  // reference model state
  logic [1:0] mS1 = 0, mS2 = 0, mCand = 0, mStab = 0;
  int         mCnt = 0;
  bit         mPend = 1, mFlag = 0;
  logic [7:0] mIe = 0, mCfg = 0, mRd = 0;

  jack_irq_ctrl #(.BASE_TICKS(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .senseCode(senseCode),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .irqN(irqN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tickEn <= (tickDiv <= 1) ? 1'b1 : ((cyc % tickDiv) == 0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mS1 = 0; mS2 = 0; mCand = 0; mStab = 0; mCnt = 0;
      mPend = 1; mFlag = 0; mIe = 0; mCfg = 0; mRd = 0;
    end else begin
      bit commit;
      bit rdStat;
      commit = 0;
      rdStat = regRdEn && regAddr == 8'h00;
      if (regRdEn) begin
        if (regAddr == 8'h00)      mRd = mFlag ? 8'h02 : 8'h00;
        else if (regAddr == 8'h01) mRd = {mStab, 6'b0};
        else if (regAddr == 8'h04) mRd = mIe;
        else if (regAddr == 8'h25) mRd = mCfg;
        else                       mRd = 8'h00;
      end
      if (!mCfg[7]) begin
        mCand = 0; mStab = 0; mCnt = 0; mPend = 1;
      end else if (mPend) begin
        mCand = mS2; mStab = mS2; mCnt = 0; mPend = 0;
      end else if (mS2 != mCand) begin
        mCand = mS2; mCnt = 0;
      end else if (mCand != mStab && tickEn) begin
        if (mCnt + 1 >= (BASE << mCfg[1:0])) begin
          mStab = mCand; mCnt = 0; commit = 1;
        end else mCnt++;
      end
      mFlag = commit || (mFlag && !rdStat);
      if (regWrEn && regAddr == 8'h04) mIe = regWrData;
      if (regWrEn && regAddr == 8'h25) mCfg = regWrData;
      mS2 = mS1;
      mS1 = senseCode;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic expIrq;
      expIrq = !(mFlag && mIe[1]);
      vectors++;
      if (irqN !== expIrq) begin
        fails++;
        $display("FAIL %s cycle %0d irqN actual %b expected %b", curReq, cyc, irqN, expIrq);
      end
      vectors++;
      if (regRdData !== mRd) begin
        fails++;
        $display("FAIL %s cycle %0d regRdData actual %h expected %h", curReq, cyc, regRdData, mRd);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    step(1);
    regWrEn = 1'b0;
  endtask

  task automatic chkRd(input logic [7:0] a, input logic [7:0] exp, input string req);
    regAddr = a; regRdEn = 1'b1;
    step(1);
    regRdEn = 1'b0;
    vectors++;
    if (regRdData !== exp) begin
      fails++;
      $display("FAIL %s read %h actual %h expected %h", req, a, regRdData, exp);
    end
  endtask

  task automatic chkIrq(input logic exp, input string req);
    vectors++;
    if (irqN !== exp) begin
      fails++;
      $display("FAIL %s irqN actual %b expected %b", req, irqN, exp);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    curReq = "R1";
    chkIrq(1'b1, "R1");
    chkRd(8'h00, 8'h00, "R1");
    chkRd(8'h01, 8'h00, "R1");
    chkRd(8'h04, 8'h00, "R1");
    chkRd(8'h25, 8'h00, "R1");

    curReq = "R2";
    wr(8'h04, 8'h02);
    wr(8'h25, 8'h80);
    wr(8'h00, 8'hFF);
    wr(8'h01, 8'hFF);
    chkRd(8'h04, 8'h02, "R2");
    chkRd(8'h25, 8'h80, "R2");
    chkRd(8'h00, 8'h00, "R2");
    chkRd(8'h01, 8'h00, "R2");
    chkRd(8'h33, 8'h00, "R2");
    step(3);
    vectors++;
    if (regRdData !== 8'h00) begin
      fails++;
      $display("FAIL R2 held read actual %h expected %h", regRdData, 8'h00);
    end

    // plug to mid, 25 ticks every cycle
    curReq = "R4";
    senseCode = 2'b01;
    step(10);
    chkIrq(1'b1, "R4");
    step(30);
    chkIrq(1'b0, "R6");
    step(5);
    chkIrq(1'b0, "R6");
    curReq = "R7";
    chkRd(8'h00, 8'h02, "R7");
    chkIrq(1'b1, "R7");
    chkRd(8'h00, 8'h00, "R7");
    chkRd(8'h01, 8'h40, "R3");

    // bounce to high and back
    curReq = "R5";
    senseCode = 2'b11; step(12);
    senseCode = 2'b01; step(40);
    chkIrq(1'b1, "R5");
    chkRd(8'h01, 8'h40, "R5");
    senseCode = 2'b11; step(15);
    senseCode = 2'b00; step(15);
    chkIrq(1'b1, "R5");
    step(20);
    chkIrq(1'b0, "R5");
    chkRd(8'h00, 8'h02, "R5");
    chkRd(8'h01, 8'h00, "R3");

    // longest debounce, ticks every other cycle
    curReq = "R4";
    wr(8'h25, 8'h83);
    tickDiv = 2;
    senseCode = 2'b11;
    step(350);
    chkIrq(1'b1, "R4");
    step(70);
    chkIrq(1'b0, "R4");
    chkRd(8'h00, 8'h02, "R4");
    chkRd(8'h01, 8'hC0, "R3");
    tickDiv = 1;

    // mid-length debounce and masked interrupt
    curReq = "R8";
    wr(8'h25, 8'h81);
    wr(8'h04, 8'h00);
    senseCode = 2'b10;
    step(60);
    chkIrq(1'b1, "R8");
    wr(8'h04, 8'h02);
    chkIrq(1'b0, "R8");
    chkRd(8'h01, 8'h80, "R3");
    chkRd(8'h00, 8'h02, "R8");

    // read coinciding with commit
    curReq = "R7";
    wr(8'h25, 8'h80);
    senseCode = 2'b01;
    regAddr = 8'h00; regRdEn = 1'b1;
    step(40);
    regRdEn = 1'b0;
    step(2);
    chkIrq(1'b1, "R7");

    // detect disable and re-enable
    curReq = "R9";
    wr(8'h25, 8'h00);
    senseCode = 2'b11;
    step(60);
    chkIrq(1'b1, "R9");
    chkRd(8'h01, 8'h00, "R9");
    chkRd(8'h00, 8'h00, "R9");
    wr(8'h25, 8'h82);
    step(150);
    chkIrq(1'b1, "R9");
    chkRd(8'h01, 8'hC0, "R9");
    chkRd(8'h00, 8'h00, "R9");

    finishRun();
  end

  initial begin
    while (cyc < WATCHDOG) @(negedge clk);
    fails++;
    $display("FAIL watchdog expired actual %0d expected below %0d", cyc, WATCHDOG);
    finishRun();
  end
endmodule